// File: doc/BRIEF.md
# Coarse-Fine Pulse-Width Time-to-Digital Converter

This block measures how long a single-bit input stays high, counted in periods of a fast shift clock. A running time base is built from two parts. The fine part is a one-hot ring of stages that rotates on every shift-clock edge, followed by an encoder that turns the ring position into a small binary code. The coarse part is a binary counter that steps once per full revolution of the ring. Placed side by side, the coarse count as the upper field and the fine code as the lower field form a time value that rises by one on every shift clock.

The measured input first passes through a two-flop synchronizer. When a rising or falling edge is detected, the time base is captured. One shift clock later it is captured a second time, and the two samples are reconciled into a single corrected timestamp. At the falling edge, the rising-edge timestamp is subtracted from the falling-edge timestamp, modulo the time-base range. The difference is presented with a one-cycle valid strobe. If the pulse lasts for the full time-base range or longer, an overflow flag is raised together with the strobe.

Top module: `pulse_tdc`

## Requirements
- R1: While reset is asserted, and after reset until the first measurement completes, `width_valid_o`, `overflow_o` and `width_o` are all 0.
- R2: For a pulse that is high for N shift-clock rising edges, with 1 <= N <= 4095, the reported width equals N.
- R3: The fine ring holds exactly one high stage at all times. The encoder gives code 0 for the stage that is high after reset, and the code advances by one modulo 16 on every shift clock.
- R4: The coarse counter advances by one on exactly the shift clock on which the fine code wraps from 15 to 0, and holds its value on every other clock.
- R5: The width word is {coarse[7:0], fine[3:0]}, and widths are computed modulo 4096. Pulses that cross fine-to-coarse carry boundaries and time-base wraparound still report N.
- R6: `width_valid_o` is high for exactly one shift clock. It rises on the fourth shift-clock edge after the first edge that samples the input low: two edges for synchronization, one for the first capture and one for the corrected result.
- R7: If N >= 4096, `overflow_o` is 1 in the same cycle as `width_valid_o` and `width_o` equals N mod 4096. Otherwise `overflow_o` is 0.
- R8: Each edge timestamp is taken from two captures one shift clock apart. The reconciled timestamp is the second capture minus one, so it agrees with the first capture whenever the time base advanced by exactly one.
- R9: Back-to-back pulses are measured independently. A width never depends on earlier pulses or on the length of the low gap between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_shift | input | 1 | Shift clock; one period is the time resolution |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_in | input | 1 | Measured pulse, asynchronous to the shift clock |
| width_o | output | 12 | Measured high duration in shift-clock periods |
| width_valid_o | output | 1 | One-cycle strobe marking a new width |
| overflow_o | output | 1 | Pulse lasted 4096 or more shift clocks |

## Verification
A measured width is due exactly four shift-clock edges after the edge that first sees the input low. The bench drives the input on falling edges and then checks the outputs at each of the next six falling edges. It expects the strobe, the width and the overflow flag only at the fourth of these and a quiet strobe at all the others, so that both early and late results are caught. Pulse lengths are swept exhaustively from 1 to 300 clocks, which covers every fine residue and several coarse carries, and the boundary lengths around 4096 are added. Each expected value is computed arithmetically as N mod 4096, and overflow is expected when N >= 4096.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/tdc_ring.sv
module tdc_ring #(
  parameter int RING_LEN = 16,
  localparam int FINE_W = $clog2(RING_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [FINE_W-1:0] fine_o,
  output logic              wrap_o
);
  logic [RING_LEN-1:0] ring_q, ring_d;

  always_comb begin
    ring_d = {ring_q[RING_LEN-2:0], ring_q[RING_LEN-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= {1'b1, {(RING_LEN-1){1'b0}}};
    else        ring_q <= ring_d;
  end

  // last stage maps to 0, stage k maps to k+1 (rotation order)
  always_comb begin
    fine_o = '0;
    for (int k = 0; k < RING_LEN; k++) begin
      if (ring_q[k]) fine_o = fine_o | FINE_W'((k + 1) % RING_LEN);
    end
  end

  // next edge moves the token into the last stage
  assign wrap_o = ring_q[RING_LEN-2];

  // R3: exactly one stage high
  a_r3_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring_q) == 1);
endmodule

// File: rtl/tdc_coarse.sv
module tdc_coarse #(
  parameter int COARSE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv_i,
  output logic [COARSE_W-1:0] coarse_o
);
  logic [COARSE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (adv_i) cnt_d = cnt_q + COARSE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign coarse_o = cnt_q;
endmodule

// File: rtl/tdc_capture.sv
module tdc_capture
  import tdc_pkg::*;
#(
  parameter int TIME_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] width_o,
  output logic              valid_o,
  output logic              ovf_o
);
  localparam int HC_W = TIME_W + 1;

  logic s_meta_q, s_sync_q, s_prev_q;
  logic rise_evt, fall_evt;
  logic [HC_W-1:0] hi_cnt_q, hi_cnt_d;

  logic              a_vld_q, a_vld_d;
  edge_kind_e        a_kind_q, a_kind_d;
  logic [TIME_W-1:0] a_samp_q, a_samp_d;
  logic              a_ovf_q, a_ovf_d;

  logic [TIME_W-1:0] step, resolved;
  logic [TIME_W-1:0] start_q, start_d;
  logic [TIME_W-1:0] width_q, width_d;
  logic              valid_q, valid_d, ovf_q, ovf_d;

  assign rise_evt = s_sync_q & ~s_prev_q;
  assign fall_evt = ~s_sync_q & s_prev_q;

  always_comb begin
    hi_cnt_d = hi_cnt_q;
    if (rise_evt)                       hi_cnt_d = HC_W'(1);
    else if (s_sync_q && !hi_cnt_q[TIME_W]) hi_cnt_d = hi_cnt_q + HC_W'(1);

    a_vld_d  = rise_evt | fall_evt;
    a_kind_d = fall_evt ? EDGE_FALL : EDGE_RISE;
    a_samp_d = time_i;
    a_ovf_d  = fall_evt & hi_cnt_q[TIME_W];

    // second capture one clock later reconciles the first
    step     = time_i - a_samp_q;
    resolved = (step == TIME_W'(1)) ? a_samp_q : time_i - TIME_W'(1);

    start_d = start_q;
    if (a_vld_q && a_kind_q == EDGE_RISE) start_d = resolved;

    valid_d = a_vld_q && (a_kind_q == EDGE_FALL);
    width_d = valid_d ? (resolved - start_q) : width_q;
    ovf_d   = valid_d & a_ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta_q <= 1'b0;
      s_sync_q <= 1'b0;
      s_prev_q <= 1'b0;
      hi_cnt_q <= '0;
      a_vld_q  <= 1'b0;
      a_kind_q <= EDGE_RISE;
      a_samp_q <= '0;
      a_ovf_q  <= 1'b0;
      start_q  <= '0;
      width_q  <= '0;
      valid_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      s_meta_q <= pulse_i;
      s_sync_q <= s_meta_q;
      s_prev_q <= s_sync_q;
      hi_cnt_q <= hi_cnt_d;
      a_vld_q  <= a_vld_d;
      a_kind_q <= a_kind_d;
      a_samp_q <= a_samp_d;
      a_ovf_q  <= a_ovf_d;
      start_q  <= start_d;
      width_q  <= width_d;
      valid_q  <= valid_d;
      ovf_q    <= ovf_d;
    end
  end

  assign width_o = width_q;
  assign valid_o = valid_q;
  assign ovf_o   = ovf_q;

  // R8: time base advanced by exactly one between the two captures
  a_r8_capture_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld_q |-> (time_i - a_samp_q) == TIME_W'(1));
  // R6: strobe lasts one cycle
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R7: overflow only alongside the strobe
  a_r7_ovf_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> valid_q);
endmodule

// File: rtl/pulse_tdc.sv
module pulse_tdc #(
  parameter int RING_LEN = 16,
  parameter int COARSE_W = 8,
  localparam int FINE_W = $clog2(RING_LEN),
  localparam int TIME_W = COARSE_W + FINE_W
) (
  input  logic              clk_shift,
  input  logic              rst_n,
  input  logic              pulse_in,
  output logic [TIME_W-1:0] width_o,
  output logic              width_valid_o,
  output logic              overflow_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_shift or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [FINE_W-1:0]   fine;
  logic                wrap;
  logic [COARSE_W-1:0] coarse;
  logic [TIME_W-1:0]   time_base;

  tdc_ring #(.RING_LEN(RING_LEN)) u_ring (
    .clk    (clk_shift),
    .rst_n  (rst_n_int),
    .fine_o (fine),
    .wrap_o (wrap)
  );

  tdc_coarse #(.COARSE_W(COARSE_W)) u_coarse (
    .clk      (clk_shift),
    .rst_n    (rst_n_int),
    .adv_i    (wrap),
    .coarse_o (coarse)
  );

  assign time_base = {coarse, fine};

  tdc_capture #(.TIME_W(TIME_W)) u_capture (
    .clk     (clk_shift),
    .rst_n   (rst_n_int),
    .pulse_i (pulse_in),
    .time_i  (time_base),
    .width_o (width_o),
    .valid_o (width_valid_o),
    .ovf_o   (overflow_o)
  );

  // R3: fine code steps by one each clock
  a_r3_fine_step: assert property (@(posedge clk_shift) disable iff (!rst_n_int)
    1'b1 |=> fine == $past(fine) + FINE_W'(1));
  // R4: coarse holds unless the fine code wraps
  a_r4_coarse_hold: assert property (@(posedge clk_shift) disable iff (!rst_n_int)
    (fine != {FINE_W{1'b1}}) |=> $stable(coarse));
  // R4: coarse steps on the wrap
  a_r4_coarse_step: assert property (@(posedge clk_shift) disable iff (!rst_n_int)
    (fine == {FINE_W{1'b1}}) |=> coarse == $past(coarse) + COARSE_W'(1));
endmodule

// File: tb/pulse_tdc_bench.sv
module pulse_tdc_bench;
  logic        clk_shift = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_in = 1'b0;
  logic [11:0] width_o;
  logic        width_valid_o;
  logic        overflow_o;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk_shift = ~clk_shift;

  pulse_tdc u_pulse_tdc (
    .clk_shift     (clk_shift),
    .rst_n         (rst_n),
    .pulse_in      (pulse_in),
    .width_o       (width_o),
    .width_valid_o (width_valid_o),
    .overflow_o    (overflow_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // one pulse of n clocks; results expected on the 4th negedge after the fall (R2, R5, R6, R7, R9)
  task automatic run_pulse(input int n);
    @(negedge clk_shift) pulse_in = 1'b1;
    repeat (n) @(negedge clk_shift);
    pulse_in = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk_shift);
      if (i == 4) begin
        check(width_valid_o == 1'b1, "R6 strobe due", int'(width_valid_o), 1);
        check(int'(width_o) == (n % 4096), "R2/R5 width", int'(width_o), n % 4096);
        check(overflow_o == (n >= 4096), "R7 overflow", int'(overflow_o), int'(n >= 4096));
      end else begin
        check(width_valid_o == 1'b0, "R6 strobe quiet", int'(width_valid_o), 0);
        check(overflow_o == 1'b0, "R7 overflow quiet", int'(overflow_o), 0);
      end
    end
  endtask

  always @(posedge clk_shift) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_shift);
    // R1: reset state
    check(width_valid_o == 1'b0, "R1 valid in reset", int'(width_valid_o), 0);
    check(overflow_o == 1'b0, "R1 overflow in reset", int'(overflow_o), 0);
    check(width_o == 12'd0, "R1 width in reset", int'(width_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_shift);
    check(width_valid_o == 1'b0, "R1 valid after reset", int'(width_valid_o), 0);
    check(width_o == 12'd0, "R1 width after reset", int'(width_o), 0);

    // R2, R3, R5, R9: exhaustive sweep covering every fine residue and coarse carries
    for (int n = 1; n <= 300; n++) run_pulse(n);
    // R5: carry boundaries
    run_pulse(15);
    run_pulse(16);
    run_pulse(17);
    run_pulse(255);
    run_pulse(256);
    run_pulse(4095);
    // R7: overflow boundary
    run_pulse(4096);
    run_pulse(4100);
    // R8, R9: normal pulse right after an overflow
    run_pulse(33);
    done = 1;
    finish_run();
  end
endmodule